// File: doc/BRIEF.md
# AXI Channel Latency Watchdog

This block is a passive observer placed beside an AXI connection. It watches the valid, ready and last signals of the five channels and keeps a running account of work in flight: read commands still waiting for their final data beat, write addresses still waiting for their last data beat, last data beats still waiting for their address, and completed writes still waiting for a response. For each of four channels (R, W, AW, B), a wait timer counts the idle cycles during which that channel owes a transfer but its valid is low. If a timer reaches its limit, the block raises a one-cycle timeout pulse on that channel's bit and sets a sticky flag that stays set until reset.

Each timer starts again from a moving reference point. For R this is the read address handshake or the previous R beat. For W it is the write address handshake or the previous W beat. For AW it is the last-beat handshake or the previous AW handshake. For B it is the moment a write becomes complete (the later of its address and its last data beat) or the previous response. When the input `lite_en` is high, every W beat is treated as a last beat and every R beat as the end of a read, which covers AXI4-Lite. A limit parameter of 0 removes that channel's timer, and its outputs are then tied low.

Top module: `axi_lat_watchdog`

## Requirements
- R1: Once reset has been applied, every bit of `timeout_pulse` and `timeout_sticky` reads 0.
- R2: Bit 0 (R) pulses when read commands are outstanding and `r_valid` stays low for R_MAX_WAIT consecutive cycles after an AR handshake or an R handshake. The outstanding count rises on an AR handshake and falls on an R handshake that has `r_last` high. If `r_valid` rises before the limit, there is no pulse.
- R3: Bit 1 (W) pulses when more AW handshakes than last-beat W handshakes have occurred and `w_valid` stays low for W_MAX_WAIT consecutive cycles after an AW handshake or any W handshake.
- R4: Bit 2 (AW) pulses when more last-beat W handshakes than AW handshakes have occurred and `aw_valid` stays low for AW_MAX_WAIT consecutive cycles after a last-beat W handshake or an AW handshake.
- R5: Bit 3 (B) pulses when min(AW handshakes, last-beat W handshakes) exceeds the number of B handshakes and `b_valid` stays low for B_MAX_WAIT consecutive cycles. The count starts from the cycle in which a write becomes complete (the later of its AW and its last W beat) or from a B handshake.
- R6: With `lite_en` high, every W handshake counts as a last beat and every R handshake ends a read, whatever `w_last` and `r_last` are.
- R7: While work remains outstanding, a handshake on the reference channel restarts the wait from zero. A timer does not advance while nothing is outstanding for its channel.
- R8: A violation produces exactly one pulse, even if the channel stays idle afterwards. The sticky bit is set in the same cycle as the pulse and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lite_en | input | 1 | Treat every W beat and every R beat as a last beat |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_last | input | 1 | Read data last beat |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| w_valid | input | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_last | input | 1 | Write data last beat |
| b_valid | input | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| timeout_pulse | output | 4 | One-cycle timeout per channel: bit0 R, bit1 W, bit2 AW, bit3 B |
| timeout_sticky | output | 4 | Timeout flags that stay set until reset, same bit order |

## Verification
Two functions can land on the same clock edge. In the first case, an AW handshake and a last-beat W handshake complete one write while a B handshake retires an earlier one. The B timer must restart, and the completed-write count must stay the same. In the second case, an AR handshake and a final R beat fall on the same edge. The bench sets up both cases by driving the channels in the same cycle. Its behavioural model then compares the pulse and sticky outputs on every cycle, and afterwards a count of the pulses that follow is checked against the restarted window.

// File: rtl/axi_lat_pkg.sv
package axi_lat_pkg;

  localparam int NUM_RULES = 4;
  localparam int RULE_R  = 0;
  localparam int RULE_W  = 1;
  localparam int RULE_AW = 2;
  localparam int RULE_B  = 3;

  // A write becomes complete when its address and its last beat have both been seen.
  function automatic logic write_completes(input logic aw_hs, input logic wl_hs,
                                           input logic addr_ahead, input logic data_ahead);
    return (aw_hs & wl_hs) | (aw_hs & data_ahead) | (wl_hs & addr_ahead);
  endfunction

  // Beat that ends a burst, with every beat counting as last in lite mode.
  function automatic logic final_beat(input logic hs, input logic last, input logic lite);
    return hs & (last | lite);
  endfunction

endpackage

// File: rtl/axi_lat_track.sv
module axi_lat_track
  import axi_lat_pkg::*;
#(
  parameter int OUT_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ar_hs,
  input  logic rd_done,
  input  logic aw_hs,
  input  logic wl_hs,
  input  logic b_hs,
  output logic rd_pend,
  output logic addr_ahead,
  output logic data_ahead,
  output logic resp_pend,
  output logic cpl_evt
);

  logic [OUT_W-1:0]        rd_cnt;
  logic signed [OUT_W:0]   bal;
  logic [OUT_W-1:0]        cpl_cnt;

  assign rd_pend    = (rd_cnt != '0);
  assign addr_ahead = (bal > 0);
  assign data_ahead = bal[OUT_W];
  assign resp_pend  = (cpl_cnt != '0);
  assign cpl_evt    = write_completes(aw_hs, wl_hs, addr_ahead, data_ahead);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_cnt  <= '0;
      bal     <= '0;
      cpl_cnt <= '0;
    end else begin
      rd_cnt  <= rd_cnt + OUT_W'(ar_hs) - OUT_W'(rd_done);
      bal     <= bal + $signed({{OUT_W{1'b0}}, aw_hs}) - $signed({{OUT_W{1'b0}}, wl_hs});
      cpl_cnt <= cpl_cnt + OUT_W'(cpl_evt) - OUT_W'(b_hs);
    end
  end

endmodule

// File: rtl/axi_lat_timer.sv
module axi_lat_timer #(
  parameter int unsigned MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic valid,
  input  logic pending,
  output logic pulse,
  output logic sticky
);

  localparam int CW = (MAX > 0) ? $clog2(MAX + 1) : 1;

  generate
    if (MAX == 0) begin : g_off
      logic unused_in;
      assign unused_in = &{1'b0, clk, rst_n, restart, valid, pending};
      assign pulse  = 1'b0;
      assign sticky = 1'b0;
    end else begin : g_on
      logic [CW-1:0] wait_q;
      logic          pulse_q;
      logic          sticky_q;
      logic          clear;
      logic          inc;

      assign clear = restart | valid | ~pending;
      assign inc   = ~clear & (wait_q != CW'(MAX));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          wait_q   <= '0;
          pulse_q  <= 1'b0;
          sticky_q <= 1'b0;
        end else begin
          if (clear)    wait_q <= '0;
          else if (inc) wait_q <= wait_q + 1'b1;
          pulse_q <= inc & (wait_q == CW'(MAX - 1));
          if (inc & (wait_q == CW'(MAX - 1))) sticky_q <= 1'b1;
        end
      end

      assign pulse  = pulse_q;
      assign sticky = sticky_q;
    end
  endgenerate

endmodule

// File: rtl/axi_lat_watchdog.sv
module axi_lat_watchdog
  import axi_lat_pkg::*;
#(
  parameter int unsigned R_MAX_WAIT  = 8,
  parameter int unsigned W_MAX_WAIT  = 6,
  parameter int unsigned AW_MAX_WAIT = 5,
  parameter int unsigned B_MAX_WAIT  = 10,
  parameter int          OUT_W       = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lite_en,
  input  logic       ar_valid,
  input  logic       ar_ready,
  input  logic       r_valid,
  input  logic       r_ready,
  input  logic       r_last,
  input  logic       aw_valid,
  input  logic       aw_ready,
  input  logic       w_valid,
  input  logic       w_ready,
  input  logic       w_last,
  input  logic       b_valid,
  input  logic       b_ready,
  output logic [3:0] timeout_pulse,
  output logic [3:0] timeout_sticky
);

  localparam logic [NUM_RULES*32-1:0] LIMITS =
    {32'(B_MAX_WAIT), 32'(AW_MAX_WAIT), 32'(W_MAX_WAIT), 32'(R_MAX_WAIT)};

  logic ar_hs, r_hs, aw_hs, w_hs, b_hs;
  logic rd_done, wl_hs;
  logic rd_pend, addr_ahead, data_ahead, resp_pend, cpl_evt;

  logic [NUM_RULES-1:0] restart_vec;
  logic [NUM_RULES-1:0] valid_vec;
  logic [NUM_RULES-1:0] pend_vec;

  assign ar_hs   = ar_valid & ar_ready;
  assign r_hs    = r_valid & r_ready;
  assign aw_hs   = aw_valid & aw_ready;
  assign w_hs    = w_valid & w_ready;
  assign b_hs    = b_valid & b_ready;
  assign rd_done = final_beat(r_hs, r_last, lite_en);
  assign wl_hs   = final_beat(w_hs, w_last, lite_en);

  axi_lat_track #(.OUT_W(OUT_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .ar_hs      (ar_hs),
    .rd_done    (rd_done),
    .aw_hs      (aw_hs),
    .wl_hs      (wl_hs),
    .b_hs       (b_hs),
    .rd_pend    (rd_pend),
    .addr_ahead (addr_ahead),
    .data_ahead (data_ahead),
    .resp_pend  (resp_pend),
    .cpl_evt    (cpl_evt)
  );

  assign restart_vec[RULE_R]  = ar_hs | r_hs;
  assign restart_vec[RULE_W]  = aw_hs | w_hs;
  assign restart_vec[RULE_AW] = wl_hs | aw_hs;
  assign restart_vec[RULE_B]  = cpl_evt | b_hs;

  assign valid_vec = {b_valid, aw_valid, w_valid, r_valid};
  assign pend_vec  = {resp_pend, data_ahead, addr_ahead, rd_pend};

  generate
    for (genvar gi = 0; gi < NUM_RULES; gi++) begin : g_rule
      axi_lat_timer #(.MAX(LIMITS[gi*32 +: 32])) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart_vec[gi]),
        .valid   (valid_vec[gi]),
        .pending (pend_vec[gi]),
        .pulse   (timeout_pulse[gi]),
        .sticky  (timeout_sticky[gi])
      );
    end
  endgenerate

endmodule

// File: rtl/axi_lat_watchdog_chk.sv
module axi_lat_watchdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] valid_vec,
  input logic [3:0] pend_vec,
  input logic [3:0] pulse,
  input logic [3:0] sticky
);

  a_r1_clear_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (pulse == 4'b0 && sticky == 4'b0));

  generate
    for (genvar gi = 0; gi < 4; gi++) begin : g_chk
      a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse[gi] |=> !pulse[gi]);
      a_r8_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
        pulse[gi] |-> sticky[gi]);
      a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sticky[gi] |=> sticky[gi]);
      a_r7_idle_before_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse[gi]) |-> $past(pend_vec[gi] && !valid_vec[gi]));
    end
  endgenerate

endmodule

bind axi_lat_watchdog axi_lat_watchdog_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid_vec (valid_vec),
  .pend_vec  (pend_vec),
  .pulse     (timeout_pulse),
  .sticky    (timeout_sticky)
);

// File: tb/tb_axi_lat_watchdog.sv
`timescale 1ns/1ps
module tb_axi_lat_watchdog;

  localparam int LIM [4] = '{8, 6, 5, 10};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lite_en = 1'b0;
  logic ar_valid = 0, ar_ready = 0, r_valid = 0, r_ready = 0, r_last = 0;
  logic aw_valid = 0, aw_ready = 0, w_valid = 0, w_ready = 0, w_last = 0;
  logic b_valid = 0, b_ready = 0;
  logic [3:0] timeout_pulse, timeout_sticky;

  always #5 clk = ~clk;

  axi_lat_watchdog #(
    .R_MAX_WAIT(8), .W_MAX_WAIT(6), .AW_MAX_WAIT(5), .B_MAX_WAIT(10), .OUT_W(6)
  ) dut (
    .clk(clk), .rst_n(rst_n), .lite_en(lite_en),
    .ar_valid(ar_valid), .ar_ready(ar_ready),
    .r_valid(r_valid), .r_ready(r_ready), .r_last(r_last),
    .aw_valid(aw_valid), .aw_ready(aw_ready),
    .w_valid(w_valid), .w_ready(w_ready), .w_last(w_last),
    .b_valid(b_valid), .b_ready(b_ready),
    .timeout_pulse(timeout_pulse), .timeout_sticky(timeout_sticky)
  );

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit done = 0;

  // Behavioural reference model
  int m_rd, m_aw, m_wl, m_b;
  int m_wait [4];
  logic [3:0] exp_p, exp_s;
  int pc [4];

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n) begin
      m_rd = 0; m_aw = 0; m_wl = 0; m_b = 0;
      for (int i = 0; i < 4; i++) m_wait[i] = 0;
      exp_p = '0; exp_s = '0;
    end else begin
      bit arh, rh, awh, wh, bh, rdd, wlh, paired;
      bit pend [4];
      bit rs [4];
      bit vl [4];
      int naw, nwl;
      arh = ar_valid && ar_ready;
      rh  = r_valid && r_ready;
      awh = aw_valid && aw_ready;
      wh  = w_valid && w_ready;
      bh  = b_valid && b_ready;
      rdd = rh && (r_last || lite_en);
      wlh = wh && (w_last || lite_en);
      pend[0] = m_rd > 0;
      pend[1] = m_aw > m_wl;
      pend[2] = m_wl > m_aw;
      pend[3] = (imin(m_aw, m_wl) - m_b) > 0;
      naw = m_aw + int'(awh);
      nwl = m_wl + int'(wlh);
      paired = imin(naw, nwl) > imin(m_aw, m_wl);
      rs[0] = arh || rh;     vl[0] = r_valid;
      rs[1] = awh || wh;     vl[1] = w_valid;
      rs[2] = wlh || awh;    vl[2] = aw_valid;
      rs[3] = paired || bh;  vl[3] = b_valid;
      for (int i = 0; i < 4; i++) begin
        int nw;
        if (rs[i] || vl[i] || !pend[i]) nw = 0;
        else if (m_wait[i] < LIM[i]) nw = m_wait[i] + 1;
        else nw = m_wait[i];
        exp_p[i] = (nw == LIM[i]) && (m_wait[i] != LIM[i]);
        if (exp_p[i]) exp_s[i] = 1'b1;
        m_wait[i] = nw;
      end
      m_rd = m_rd + int'(arh) - int'(rdd);
      m_aw = naw; m_wl = nwl; m_b = m_b + int'(bh);
    end
  end

  string tags [4] = '{"R2", "R3", "R4", "R5"};

  always @(negedge clk) begin
    if (started && !done) begin
      for (int i = 0; i < 4; i++) begin
        checks++;
        if (timeout_pulse[i] !== exp_p[i]) begin
          errors++;
          $display("FAIL %s pulse bit %0d actual %b expected %b at %0t",
                   tags[i], i, timeout_pulse[i], exp_p[i], $time);
        end
      end
      checks++;
      if (timeout_sticky !== exp_s) begin
        errors++;
        $display("FAIL R8 sticky actual %b expected %b at %0t", timeout_sticky, exp_s, $time);
      end
      for (int i = 0; i < 4; i++) if (timeout_pulse[i] === 1'b1) pc[i]++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_int(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_pc();
    for (int i = 0; i < 4; i++) pc[i] = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    clear_pc();
  endtask

  task automatic do_ar();
    ar_valid = 1; ar_ready = 1; tick(1); ar_valid = 0; ar_ready = 0;
  endtask

  task automatic do_r(input logic last);
    r_valid = 1; r_ready = 1; r_last = last; tick(1); r_valid = 0; r_ready = 0; r_last = 0;
  endtask

  task automatic do_aw();
    aw_valid = 1; aw_ready = 1; tick(1); aw_valid = 0; aw_ready = 0;
  endtask

  task automatic do_w(input logic last);
    w_valid = 1; w_ready = 1; w_last = last; tick(1); w_valid = 0; w_ready = 0; w_last = 0;
  endtask

  task automatic do_b();
    b_valid = 1; b_ready = 1; tick(1); b_valid = 0; b_ready = 0;
  endtask

  initial begin
    clear_pc();
    tick(1);
    do_reset();
    // R1: outputs cleared after reset
    check_int("R1", "pulse after reset", int'(timeout_pulse), 0);
    check_int("R1", "sticky after reset", int'(timeout_sticky), 0);

    // R2 / R8: idle read channel times out once; R7: no counting once drained
    do_ar();
    tick(12);
    check_int("R2", "R pulses after idle read", pc[0], 1);
    check_int("R8", "R sticky set", int'(timeout_sticky[0]), 1);
    do_r(1'b1);
    tick(12);
    check_int("R7", "R pulses once drained", pc[0], 1);
    check_int("R8", "R sticky held", int'(timeout_sticky[0]), 1);

    // R2: valid raised in time, held while stalled by ready
    do_reset();
    do_ar();
    tick(3);
    r_valid = 1;
    tick(10);
    r_ready = 1; r_last = 1;
    tick(1);
    r_valid = 0; r_ready = 0; r_last = 0;
    tick(12);
    check_int("R2", "R pulses with early valid", pc[0], 0);

    // R7: previous R beat restarts the window
    do_ar();
    do_ar();
    tick(5);
    do_r(1'b1);
    tick(6);
    check_int("R7", "R pulses before restarted window", pc[0], 0);
    tick(4);
    check_int("R7", "R pulses after restarted window", pc[0], 1);
    do_r(1'b1);

    // R3 then R5: address first, data late, response late
    do_reset();
    do_aw();
    tick(10);
    check_int("R3", "W pulses after idle write data", pc[1], 1);
    do_w(1'b1);
    tick(5);
    check_int("R5", "B pulses early", pc[3], 0);
    tick(8);
    check_int("R5", "B pulses after idle response", pc[3], 1);
    do_b();
    tick(12);
    check_int("R5", "B pulses after response", pc[3], 1);

    // R4: data first, address late; then prompt response
    do_reset();
    do_w(1'b1);
    tick(8);
    check_int("R4", "AW pulses after idle address", pc[2], 1);
    do_aw();
    tick(3);
    do_b();
    tick(15);
    check_int("R5", "B pulses with prompt response", pc[3], 0);

    // R6: lite mode, non-last beats complete bursts
    do_reset();
    lite_en = 1'b1;
    do_w(1'b0);
    tick(8);
    check_int("R6", "AW pulses in lite mode", pc[2], 1);
    do_aw();
    do_b();
    do_ar();
    tick(2);
    do_r(1'b0);
    tick(12);
    check_int("R6", "R pulses after lite read beat", pc[0], 0);
    check_int("R6", "W pulses in lite mode", pc[1], 0);
    lite_en = 1'b0;

    // Same-cycle events: write completes while a response retires another
    do_reset();
    aw_valid = 1; aw_ready = 1; w_valid = 1; w_ready = 1; w_last = 1;
    tick(1);
    aw_valid = 0; aw_ready = 0; w_valid = 0; w_ready = 0; w_last = 0;
    tick(4);
    aw_valid = 1; aw_ready = 1; w_valid = 1; w_ready = 1; w_last = 1; b_valid = 1; b_ready = 1;
    tick(1);
    aw_valid = 0; aw_ready = 0; w_valid = 0; w_ready = 0; w_last = 0; b_valid = 0; b_ready = 0;
    tick(8);
    check_int("R5", "B pulses inside restarted window", pc[3], 0);
    tick(3);
    check_int("R5", "B pulses after restarted window", pc[3], 1);
    do_b();
    // AR and final R beat on one edge keeps one read outstanding
    do_ar();
    ar_valid = 1; ar_ready = 1; r_valid = 1; r_ready = 1; r_last = 1;
    tick(1);
    ar_valid = 0; ar_ready = 0; r_valid = 0; r_ready = 0; r_last = 0;
    tick(7);
    check_int("R7", "R pulses inside window after joint edge", pc[0], 0);
    tick(2);
    check_int("R7", "R pulses after joint edge window", pc[0], 1);
    do_r(1'b1);

    // R1: reset clears sticky flags mid-run
    do_reset();
    check_int("R1", "sticky after mid-run reset", int'(timeout_sticky), 0);

    tick(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule